// File: doc/BRIEF.md
# Two-Level Cache Write Policy Controller

This controller accepts one memory request at a time and turns it into an ordered list of action commands for a primary data cache, a secondary cache and main memory. A request carries an access kind (load, instruction fetch or store), a hit flag for each cache level and a per-page caching attribute. The attribute is one of uncached, write-through with allocate, write-through without allocate, write-back, or write-back that bypasses the secondary. The command list is fixed when the request is accepted. The commands are then issued one at a time, and each one waits for an acknowledge before the next is shown.

The secondary only holds lines that are managed as write-back. Write-through lines are never placed there, and the bypass attribute neither looks the secondary up nor fills it. The uncached attribute, and any attribute code outside the legal set, sends the access straight to memory. An illegal code also raises a one-cycle error flag.

The controller has two states. ST_IDLE accepts a request whenever `req_valid` is high. The transition IDLE→ISSUE is taken when the accepted request has at least one command. A request with no commands stays in IDLE. ST_ISSUE presents the current command. The transition ISSUE→ISSUE, which advances to the next command, is taken on an acknowledge of any command except the last. The transition ISSUE→IDLE is taken on the acknowledge of the last command.

Top module: `cwp_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `cmd_valid` is 0 and `attr_err` is 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle, `req_ready` stays 0 until the edge that samples `cmd_ack` for the last command, and it is 1 in the cycle after that edge. While `cmd_valid` is 1 and `cmd_ack` is 0, `cmd_op` holds its value. The command codes are: 0 primary update, 1 primary fill, 2 secondary lookup, 3 secondary fill, 4 secondary write (reserved, never issued), 5 memory read, 6 memory write, 7 dirty-bit set.
- R3: The attribute codes are 0 uncached, 1 write-through with allocate, 2 write-through without allocate, 3 write-back and 4 write-back with secondary bypass. The kind codes are 0 load, 1 instruction fetch and 2 store; kind 3 is handled as a load. Under the uncached attribute, a load or fetch issues only a memory read (5), and a store issues only a memory write (6).
- R4: An attribute code of 5, 6 or 7 is handled exactly as uncached. `attr_err` is 1 in the single cycle after such a request is accepted and 0 otherwise.
- R5: Under any cacheable attribute (1 to 4), a load or fetch that hits the primary issues no command, and `req_ready` stays 1.
- R6: Under write-back, a load or fetch that misses the primary issues a secondary lookup (2). It then issues a primary fill (1) if the secondary hits. If the secondary misses, it issues a memory read (5), a secondary fill (3) and a primary fill (1), in that order.
- R7: Under either write-through attribute or the bypass attribute, a load or fetch that misses the primary issues a memory read (5) and then a primary fill (1). No secondary command is issued.
- R8: Under write-through with allocate, a store hit issues a primary update (0) then a memory write (6). A store miss issues a memory read (5), a primary fill (1), a primary update (0) and a memory write (6), in that order. Neither case issues a dirty-bit set.
- R9: Under write-through without allocate, a store hit issues a primary update (0) then a memory write (6). A store miss issues only a memory write (6).
- R10: Under write-back, a store hit issues a primary update (0) then a dirty-bit set (7). A store miss first issues a secondary lookup (2). If the secondary hits, this is followed by a primary fill (1), a primary update (0) and a dirty-bit set (7). If the secondary misses, it is followed by a memory read (5), a secondary fill (3), a primary fill (1), a primary update (0) and a dirty-bit set (7).
- R11: Under the bypass attribute, a store hit issues a primary update (0) then a dirty-bit set (7). A store miss issues a memory read (5), a primary fill (1), a primary update (0) and a dirty-bit set (7). No secondary command is issued.
- R12: A secondary fill (3) is issued only for requests whose attribute is write-back (3).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_kind | input | 2 | Access kind code |
| req_attr | input | 3 | Caching attribute code |
| req_p_hit | input | 1 | Primary hit for the request |
| req_s_hit | input | 1 | Secondary hit for the request |
| cmd_valid | output | 1 | Command presented |
| cmd_op | output | 3 | Command code |
| cmd_ack | input | 1 | Command done |
| attr_err | output | 1 | Illegal attribute pulse |

## Verification
The assertions assume that the request fields, including both hit flags, are valid on the accepting edge. They also assume that `cmd_ack` is only raised while `cmd_valid` is 1. The bench drives requests only when `req_ready` is 1 and holds the fields steady across the accepting edge. It raises the acknowledge only after it has seen a command, for a single cycle, after a random delay of zero to two cycles. Kinds are drawn from 0 to 2 and attributes from the full 0 to 7 range, so illegal codes are exercised while every legal code stays within those assumptions.

// File: rtl/cwp_pkg.sv
package cwp_pkg;

    typedef enum logic [2:0] {
        OP_PUPD  = 3'd0,
        OP_PFILL = 3'd1,
        OP_SLOOK = 3'd2,
        OP_SFILL = 3'd3,
        OP_SWR   = 3'd4,
        OP_MRD   = 3'd5,
        OP_MWR   = 3'd6,
        OP_DIRTY = 3'd7
    } op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } st_e;

    localparam logic [2:0] ATTR_UNC = 3'd0;
    localparam logic [2:0] ATTR_WTA = 3'd1;
    localparam logic [2:0] ATTR_WTN = 3'd2;
    localparam logic [2:0] ATTR_WB  = 3'd3;
    localparam logic [2:0] ATTR_WBX = 3'd4;

    localparam logic [1:0] KIND_STORE = 2'd2;

    localparam int MAX_STEPS = 6;
    localparam int CNT_W     = $clog2(MAX_STEPS + 1);
    localparam int IDX_W     = $clog2(MAX_STEPS);

    typedef op_e oplist_t [MAX_STEPS];

endpackage

// File: rtl/cwp_planner.sv
module cwp_planner
    import cwp_pkg::*;
(
    input  logic [1:0]       kind,
    input  logic [2:0]       attr,
    input  logic             p_hit,
    input  logic             s_hit,
    output oplist_t          ops,
    output logic [CNT_W-1:0] count,
    output logic             illegal
);

    logic [2:0]       eff;
    logic             is_st;
    logic [CNT_W-1:0] n;

    always_comb begin
        for (int i = 0; i < MAX_STEPS; i++) ops[i] = OP_PUPD;
        n       = '0;
        illegal = (attr > ATTR_WBX);
        eff     = illegal ? ATTR_UNC : attr;
        is_st   = (kind == KIND_STORE);

        if (eff == ATTR_UNC) begin
            ops[0] = is_st ? OP_MWR : OP_MRD;
            n      = 1;
        end else if (!is_st) begin
            if (!p_hit) begin
                if (eff == ATTR_WB) begin
                    ops[n] = OP_SLOOK; n = n + 1'b1;
                    if (!s_hit) begin
                        ops[n] = OP_MRD;   n = n + 1'b1;
                        ops[n] = OP_SFILL; n = n + 1'b1;
                    end
                end else begin
                    ops[n] = OP_MRD; n = n + 1'b1;
                end
                ops[n] = OP_PFILL; n = n + 1'b1;
            end
        end else if (eff == ATTR_WTN && !p_hit) begin
            ops[0] = OP_MWR;
            n      = 1;
        end else begin
            if (!p_hit) begin
                if (eff == ATTR_WB) begin
                    ops[n] = OP_SLOOK; n = n + 1'b1;
                    if (!s_hit) begin
                        ops[n] = OP_MRD;   n = n + 1'b1;
                        ops[n] = OP_SFILL; n = n + 1'b1;
                    end
                end else begin
                    ops[n] = OP_MRD; n = n + 1'b1;
                end
                ops[n] = OP_PFILL; n = n + 1'b1;
            end
            ops[n] = OP_PUPD; n = n + 1'b1;
            if (eff == ATTR_WTA || eff == ATTR_WTN) ops[n] = OP_MWR;
            else                                    ops[n] = OP_DIRTY;
            n = n + 1'b1;
        end
        count = n;
    end

    // Plan checks guarding the policy tables
    always_comb begin
        for (int i = 0; i < MAX_STEPS; i++) begin
            if (i < int'(count) && ops[i] == OP_SFILL)
                p_sfill_wb_only_r12: assert (attr == ATTR_WB);
        end
        if (attr == ATTR_UNC || attr > ATTR_WBX)
            p_uncached_single_r3: assert (count == 1);
    end

endmodule

// File: rtl/cwp_seq.sv
module cwp_seq
    import cwp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  oplist_t          plan_ops,
    input  logic [CNT_W-1:0] plan_cnt,
    input  logic             plan_illegal,
    input  logic             cmd_ack,
    output logic             req_ready,
    output logic             cmd_valid,
    output op_e              cmd_op,
    output logic             attr_err
);

    st_e              state, state_nx;
    oplist_t          steps;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] idx;
    logic             err_q;
    logic             accept;
    logic             last;

    assign accept = req_valid && (state == ST_IDLE);
    assign last   = ({1'b0, idx} == CNT_W'(cnt - 1'b1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept && plan_cnt != '0) state_nx = ST_ISSUE;
            ST_ISSUE: if (cmd_ack && last)          state_nx = ST_IDLE;
        endcase
    end

    // sequence storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_STEPS; i++) steps[i] <= OP_PUPD;
            cnt   <= '0;
            idx   <= '0;
            err_q <= 1'b0;
        end else begin
            err_q <= accept && plan_illegal;
            if (accept) begin
                steps <= plan_ops;
                cnt   <= plan_cnt;
                idx   <= '0;
            end else if (state == ST_ISSUE && cmd_ack && !last) begin
                idx <= idx + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = (state == ST_IDLE);
        cmd_valid = (state == ST_ISSUE);
        cmd_op    = steps[idx];
        attr_err  = err_q;
    end

    p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !req_ready);
    p_cmd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ack |=> cmd_valid && $stable(cmd_op));
    p_ready_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ack && last |=> req_ready);
    p_err_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        attr_err |=> !attr_err);
    p_err_after_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        attr_err |-> $past(req_valid && req_ready));

endmodule

// File: rtl/cwp_ctrl.sv
module cwp_ctrl
    import cwp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic [1:0] req_kind,
    input  logic [2:0] req_attr,
    input  logic       req_p_hit,
    input  logic       req_s_hit,
    output logic       cmd_valid,
    output logic [2:0] cmd_op,
    input  logic       cmd_ack,
    output logic       attr_err
);

    oplist_t          plan_ops;
    logic [CNT_W-1:0] plan_cnt;
    logic             plan_illegal;
    op_e              op_q;

    cwp_planner u_plan (
        .kind    (req_kind),
        .attr    (req_attr),
        .p_hit   (req_p_hit),
        .s_hit   (req_s_hit),
        .ops     (plan_ops),
        .count   (plan_cnt),
        .illegal (plan_illegal)
    );

    cwp_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .plan_ops     (plan_ops),
        .plan_cnt     (plan_cnt),
        .plan_illegal (plan_illegal),
        .cmd_ack      (cmd_ack),
        .req_ready    (req_ready),
        .cmd_valid    (cmd_valid),
        .cmd_op       (op_q),
        .attr_err     (attr_err)
    );

    assign cmd_op = op_q;

endmodule

// File: tb/cwp_ctrl_test.sv
`timescale 1ns/1ps
module cwp_ctrl_test;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       req_valid = 0;
    logic       req_ready;
    logic [1:0] req_kind = 0;
    logic [2:0] req_attr = 0;
    logic       req_p_hit = 0;
    logic       req_s_hit = 0;
    logic       cmd_valid;
    logic [2:0] cmd_op;
    logic       cmd_ack = 0;
    logic       attr_err;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    int exp_ops [6];
    int exp_n;

    always #10 clk = ~clk;

    cwp_ctrl uut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, expv, $time);
        end
    endtask

    function automatic void put(input int op);
        exp_ops[exp_n] = op;
        exp_n++;
    endfunction

    // expected command list from the requirement text
    function automatic string build(input int k, input int a, input bit ph, input bit sh);
        bit st = (k == 2);
        exp_n = 0;
        if (a == 0 || a > 4) begin
            put(st ? 6 : 5);
            return (a > 4) ? "R4" : "R3";
        end
        if (!st) begin
            if (ph) return "R5";
            if (a == 3) begin
                put(2);
                if (!sh) begin put(5); put(3); end
                put(1);
                return "R6";
            end
            put(5); put(1);
            return "R7";
        end
        case (a)
            1: begin
                if (!ph) begin put(5); put(1); end
                put(0); put(6); return "R8";
            end
            2: begin
                if (ph) begin put(0); put(6); end
                else put(6);
                return "R9";
            end
            3: begin
                if (!ph) begin
                    put(2);
                    if (!sh) begin put(5); put(3); end
                    put(1);
                end
                put(0); put(7); return "R10";
            end
            default: begin
                if (!ph) begin put(5); put(1); end
                put(0); put(7); return "R11";
            end
        endcase
    endfunction

    task automatic run_req(input int k, input int a, input bit ph, input bit sh);
        string tag;
        tag = build(k, a, ph, sh);
        @(negedge clk);
        chk(req_ready == 1'b1, "R2", int'(req_ready), 1);
        req_kind = 2'(k); req_attr = 3'(a); req_p_hit = ph; req_s_hit = sh;
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        chk(attr_err == (a > 4), "R4", int'(attr_err), int'(a > 4));
        chk(req_ready == (exp_n == 0), (exp_n == 0) ? "R5" : "R2", int'(req_ready), int'(exp_n == 0));
        for (int i = 0; i < exp_n; i++) begin
            int d = int'($urandom % 3);
            chk(cmd_valid == 1'b1, tag, int'(cmd_valid), 1);
            chk(int'(cmd_op) == exp_ops[i], tag, int'(cmd_op), exp_ops[i]);
            if (cmd_op == 3'd3) chk(a == 3, "R12", a, 3);
            chk(req_ready == 1'b0, "R2", int'(req_ready), 0);
            for (int w = 0; w < d; w++) begin
                @(negedge clk);
                chk(int'(cmd_op) == exp_ops[i], "R2", int'(cmd_op), exp_ops[i]);
                chk(attr_err == 1'b0, "R4", int'(attr_err), 0);
            end
            cmd_ack = 1;
            @(negedge clk);
            cmd_ack = 0;
        end
        chk(req_ready == 1'b1, "R2", int'(req_ready), 1);
        chk(cmd_valid == 1'b0, tag, int'(cmd_valid), 0);
        if (exp_n > 0) chk(attr_err == 1'b0, "R4", int'(attr_err), 0);
    endtask

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", int'(req_ready), 1);
        chk(cmd_valid == 1'b0, "R1", int'(cmd_valid), 0);
        chk(attr_err == 1'b0, "R1", int'(attr_err), 0);
        // directed corners
        run_req(0, 0, 1, 1);   // R3 uncached load despite hit
        run_req(2, 0, 1, 0);   // R3 uncached store
        run_req(2, 7, 0, 0);   // R4 illegal store
        run_req(1, 5, 1, 1);   // R4 illegal fetch
        run_req(0, 3, 1, 0);   // R5
        run_req(0, 3, 0, 1);   // R6 secondary hit
        run_req(1, 3, 0, 0);   // R6 secondary miss
        run_req(0, 4, 0, 1);   // R7 bypass ignores s hit
        run_req(2, 1, 0, 0);   // R8 miss
        run_req(2, 2, 0, 1);   // R9 miss
        run_req(2, 3, 0, 0);   // R10 longest list
        run_req(2, 3, 0, 1);   // R10 secondary hit
        run_req(2, 4, 0, 0);   // R11 miss
        run_req(2, 4, 1, 0);   // R11 hit
        for (int r = 0; r < 400; r++)
            run_req(int'($urandom % 3), int'($urandom % 8), bit'($urandom % 2), bit'($urandom % 2));
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule